// File: doc/BRIEF.md
# Serial Channel Run-Control Register Bank

This block holds the run/stop state of every channel of a small multi-channel serial unit, together with one serial-clock output bit per channel. Software starts channels by writing ones into a start strobe word and stops them by writing ones into a separate stop strobe word. A read-only status word shows which channels are running. The registered per-channel enable outputs tell the shift engines when to operate. The engines themselves sit outside this block.

Each channel also has a clock-output bit that drives its serial clock pin. While a channel runs, the pin follows the clock supplied by that channel's engine, and the bit follows that clock. Software writes to the bit are dropped while the channel runs. Once the channel is stopped, the bit keeps the last engine level, and software may write it directly. This lets software shape start and stop conditions on the clock line by hand.

The channel count is a parameter. A four-channel unit and a two-channel unit are both built from the same source. Register offsets on the two-bit word address are: 0 status, 1 start strobe, 2 stop strobe, 3 clock-output bits. Channel n always uses bit n of the data word.

Top module: `chan_run_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every enable output and every status bit is 0, every clock-output bit is 1, and so every clock pin is 1.
- R2: A bus write to offset 1 sets the enable of each channel whose data bit is 1. Data bits of 0 leave their channel unchanged.
- R3: A bus write to offset 2 clears the enable of each channel whose data bit is 1. Data bits of 0 leave their channel unchanged.
- R4: The enable outputs are registered and change only on the clock edge that accepts a write to offset 1 or 2. At all other edges they hold.
- R5: A read of offset 0 returns the enables in bits NUM_CH-1..0, with 1 meaning running. Bits above NUM_CH-1 read 0. A write to offset 0 has no effect.
- R6: Reads of offsets 1 and 2 return 0.
- R7: While a channel is enabled, its pin equals its engine clock input. Writes to its clock-output bit are ignored.
- R8: While a channel is stopped, a write to offset 3 loads the channel's clock-output bit from data bit n. From the next edge on, the pin drives that value and holds it until the next such write or until the channel is restarted.
- R9: On the edge that stops a channel, its clock-output bit captures the engine clock level present at that edge, so the pin keeps that level afterwards.
- R10: A read of offset 3 returns the clock-output bits in bits NUM_CH-1..0 and 0 above. All read data appears on the edge after the read request and is 0 after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the read request |
| chan_en | output | NUM_CH | Registered run enable per channel |
| eng_sck | input | NUM_CH | Serial clock from each channel engine |
| sck_pin | output | NUM_CH | Serial clock pin level per channel |

## Verification
Two functions can act on a channel's clock-output bit in the same cycle: a software write to offset 3 and the capture of the engine clock on a running channel. The same is true of the stop edge and a moving engine clock. The bench provokes both. It writes clock values while some channels run and others are stopped, and it toggles the engine clock on the edge that issues a stop. A behavioural model is advanced on every edge and judges the pin, the enable and the read data after each edge. A second, two-channel instance on the same bus confirms that the upper status bits read 0.

// File: rtl/runctl_pkg.sv
// runctl_pkg: shared constants and types for the channel run-control bank.
// Assumes a 16-bit data word and a two-bit word offset.
package runctl_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    // Word offsets of the register map.
    typedef enum logic [ADDR_W-1:0] {
        OFS_STATUS = 2'd0,
        OFS_START  = 2'd1,
        OFS_STOP   = 2'd2,
        OFS_CKOUT  = 2'd3
    } ofs_e;

    // Decoded bus command for one cycle.
    typedef struct packed {
        logic start_wr;
        logic stop_wr;
        logic ckout_wr;
        logic rd;
    } bus_cmd_t;
endpackage

// File: rtl/runctl_bus_decode.sv
// runctl_bus_decode: turns the raw bus request into one-hot register strobes.
// Assumes at most one access per cycle; offset 0 writes decode to nothing.
module runctl_bus_decode
    import runctl_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_cmd_t          cmd
);
    // Decode the access type and offset into strobes.
    always_comb begin
        cmd          = '0;
        cmd.rd       = bus_sel && !bus_wr;
        cmd.start_wr = bus_sel && bus_wr && (bus_addr == OFS_START);
        cmd.stop_wr  = bus_sel && bus_wr && (bus_addr == OFS_STOP);
        cmd.ckout_wr = bus_sel && bus_wr && (bus_addr == OFS_CKOUT);
    end
endmodule

// File: rtl/runctl_chan_cell.sv
// runctl_chan_cell: run enable and clock-output bit of one channel.
// Assumes start and stop requests come as single-cycle strobes; a
// simultaneous stop beats start. The clock bit follows the engine while
// running and is software-writable only while stopped.
module runctl_chan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic ck_wr,
    input  logic ck_wval,
    input  logic eng_sck,
    output logic run_en,
    output logic ck_bit,
    output logic pin
);
    // Enable flop: set by start, cleared by stop, stop has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en <= 1'b0;
        end else if (clr_req) begin
            run_en <= 1'b0;
        end else if (set_req) begin
            run_en <= 1'b1;
        end
    end

    // Clock-output bit: tracks engine while running, software-loaded while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_bit <= 1'b1;
        end else if (run_en) begin
            ck_bit <= eng_sck;
        end else if (ck_wr) begin
            ck_bit <= ck_wval;
        end
    end

    // Pin select: engine clock while running, held bit otherwise.
    always_comb begin
        pin = run_en ? eng_sck : ck_bit;
    end
endmodule

// File: rtl/runctl_read_mux.sv
// runctl_read_mux: registered read-data path of the bank.
// Assumes NUM_CH <= DATA_W; unused high bits and strobe offsets read 0,
// and the output is 0 after any cycle without a read.
module runctl_read_mux
    import runctl_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_CH-1:0] en_vec,
    input  logic [NUM_CH-1:0] ck_vec,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] word;

    // Select the addressed word, zero-extended to the bus width.
    always_comb begin
        word = '0;
        unique case (addr)
            OFS_STATUS: word[NUM_CH-1:0] = en_vec;
            OFS_CKOUT:  word[NUM_CH-1:0] = ck_vec;
            default:    word = '0;
        endcase
    end

    // Register read data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= rd ? word : '0;
        end
    end
endmodule

// File: rtl/chan_run_ctrl.sv
// chan_run_ctrl: run-control register bank for NUM_CH serial channels.
// Start/stop strobe words set and clear per-channel enables, a status word
// reports them, and a clock-output word drives each clock pin while the
// channel is stopped. Assumes 1 <= NUM_CH <= 16.
module chan_run_ctrl
    import runctl_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic [NUM_CH-1:0] chan_en,
    input  logic [NUM_CH-1:0] eng_sck,
    output logic [NUM_CH-1:0] sck_pin
);
    localparam int CH_LAST = NUM_CH - 1;

    bus_cmd_t          cmd;
    logic [NUM_CH-1:0] ck_vec;
    logic [NUM_CH-1:0] wd_ch;
    logic              unused_wdata;

    // Only the channel bits of the write word are consumed.
    assign wd_ch        = bus_wdata[CH_LAST:0];
    assign unused_wdata = ^bus_wdata;

    runctl_bus_decode u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .cmd      (cmd)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        runctl_chan_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (cmd.start_wr && wd_ch[n]),
            .clr_req (cmd.stop_wr && wd_ch[n]),
            .ck_wr   (cmd.ckout_wr),
            .ck_wval (wd_ch[n]),
            .eng_sck (eng_sck[n]),
            .run_en  (chan_en[n]),
            .ck_bit  (ck_vec[n]),
            .pin     (sck_pin[n])
        );
    end

    runctl_read_mux #(.NUM_CH(NUM_CH)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (cmd.rd),
        .addr   (bus_addr),
        .en_vec (chan_en),
        .ck_vec (ck_vec),
        .rdata  (bus_rdata)
    );
endmodule

// File: rtl/chan_run_ctrl_chk.sv
// chan_run_ctrl_chk: port-level properties of the run-control bank,
// attached to every instance of chan_run_ctrl by the bind below.
module chan_run_ctrl_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic [NUM_CH-1:0] chan_en,
    input logic [NUM_CH-1:0] eng_sck,
    input logic [NUM_CH-1:0] sck_pin
);
    logic wr_start, wr_stop, wr_ck, rd_strobe;
    assign wr_start  = bus_sel && bus_wr && bus_addr == 2'd1;
    assign wr_stop   = bus_sel && bus_wr && bus_addr == 2'd2;
    assign wr_ck     = bus_sel && bus_wr && bus_addr == 2'd3;
    assign rd_strobe = bus_sel && !bus_wr && (bus_addr == 2'd1 || bus_addr == 2'd2);

    assert_start_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> ((chan_en & $past(bus_wdata[NUM_CH-1:0])) == $past(bus_wdata[NUM_CH-1:0])));

    assert_stop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stop |=> ((chan_en & $past(bus_wdata[NUM_CH-1:0])) == '0));

    assert_enable_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_start || wr_stop) |=> (chan_en == $past(chan_en)));

    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((bus_rdata >> NUM_CH) == 16'd0));

    assert_strobe_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> (bus_rdata == 16'd0));

    assert_stopped_pin_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ck |=> ((sck_pin & ~chan_en & ~$past(chan_en)) ==
                    ($past(sck_pin) & ~chan_en & ~$past(chan_en))));

    assert_stop_keeps_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sck_pin & $past(chan_en) & ~chan_en) ==
                  ($past(eng_sck) & $past(chan_en) & ~chan_en)));
endmodule

bind chan_run_ctrl chan_run_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .chan_en   (chan_en),
    .eng_sck   (eng_sck),
    .sck_pin   (sck_pin)
);

// File: tb/chan_run_ctrl_bench.sv
// chan_run_ctrl_bench: behavioural model advanced every edge, compared every
// cycle, plus directed scenarios per requirement.
module chan_run_ctrl_bench;
    localparam int TCLK = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [3:0]  eng = 4'hF;
    logic [15:0] rdata, rdata2;
    logic [3:0]  en, pin;
    logic [1:0]  en2, pin2;

    int checks = 0;
    int errors = 0;
    bit live = 1'b0;
    bit done = 1'b0;

    // Model state
    bit [3:0]  m_en = '0;
    bit [3:0]  m_ck = 4'hF;
    bit [15:0] m_rd = '0;

    always #(TCLK/2) clk = ~clk;

    chan_run_ctrl #(.NUM_CH(4)) u_chan_run_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .chan_en(en), .eng_sck(eng), .sck_pin(pin)
    );

    chan_run_ctrl #(.NUM_CH(2)) u_chan_run_ctrl_two (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata2), .chan_en(en2), .eng_sck(eng[1:0]), .sck_pin(pin2)
    );

    // Reference model: one step per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_ck = 4'hF; m_rd = '0;
        end else begin
            bit [3:0] nen, nck;
            m_rd = '0;
            if (sel && !wr) begin
                if (addr == 2'd0) m_rd = {12'd0, m_en};
                if (addr == 2'd3) m_rd = {12'd0, m_ck};
            end
            nen = m_en; nck = m_ck;
            for (int n = 0; n < 4; n++) begin
                if (sel && wr && addr == 2'd1 && wdata[n]) nen[n] = 1'b1;
                if (sel && wr && addr == 2'd2 && wdata[n]) nen[n] = 1'b0;
                if (m_en[n]) nck[n] = eng[n];
                else if (sel && wr && addr == 2'd3) nck[n] = wdata[n];
            end
            m_en = nen; m_ck = nck;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (live) begin
            chk("R4 enable", {12'd0, en}, {12'd0, m_en});
            chk("R7 pin", {12'd0, pin}, {12'd0, (m_en & eng) | (~m_en & m_ck)});
            chk("R10 rdata", rdata, m_rd);
            chk("R5 rdata two-channel", rdata2, m_rd & 16'h0003);
        end
    end

    task automatic op(input logic s, input logic w, input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        sel = s; wr = w; addr = a; wdata = d;
        @(posedge clk); #1;
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        live = 1'b1;
        // R1: reset state
        chk("R1 enable", {12'd0, en}, 16'd0);
        chk("R1 pin", {12'd0, pin}, 16'h000F);
        op(1, 0, 2'd0, 0); chk("R1 status", rdata, 16'h0000);
        op(1, 0, 2'd3, 0); chk("R1 ckout", rdata, 16'h000F);
        // R2: start strobes
        op(1, 1, 2'd1, 16'h0005); chk("R2 start 0101", {12'd0, en}, 16'h0005);
        op(1, 1, 2'd1, 16'h0000); chk("R2 zero write", {12'd0, en}, 16'h0005);
        op(1, 1, 2'd1, 16'h0002); chk("R2 start 0010", {12'd0, en}, 16'h0007);
        // R3: stop strobes
        op(1, 1, 2'd2, 16'h0004); chk("R3 stop 0100", {12'd0, en}, 16'h0003);
        op(1, 1, 2'd2, 16'h0000); chk("R3 zero write", {12'd0, en}, 16'h0003);
        // R5: status read and write ignored
        op(1, 1, 2'd0, 16'hFFFF); chk("R5 status write ignored", {12'd0, en}, 16'h0003);
        op(1, 0, 2'd0, 0); chk("R5 status", rdata, 16'h0003); chk("R5 two-unit", rdata2, 16'h0003);
        // R6: strobe reads
        op(1, 0, 2'd1, 0); chk("R6 start read", rdata, 16'h0000);
        op(1, 0, 2'd2, 0); chk("R6 stop read", rdata, 16'h0000);
        // R7 / R8: ck write with ch0,1 running, ch2,3 stopped
        eng = 4'b0010;
        op(1, 1, 2'd3, 16'h0000);
        chk("R7 running pins follow engine", {14'd0, pin[1:0]}, 16'h0002);
        chk("R8 stopped pins load write", {14'd0, pin[3:2]}, 16'h0000);
        eng = 4'b1101; #1;
        chk("R7 engine toggle", {14'd0, pin[1:0]}, 16'h0001);
        chk("R8 stopped pins hold", {14'd0, pin[3:2]}, 16'h0000);
        op(1, 1, 2'd3, 16'h0008); chk("R8 ch3 written 1", {15'd0, pin[3]}, 16'h0001);
        // R9: stop ch0 while engine drives 0, then engine rises
        eng = 4'b0000;
        op(1, 1, 2'd2, 16'h0001);
        eng = 4'b1111; #1;
        chk("R9 pin keeps engine level", {15'd0, pin[0]}, 16'h0000);
        op(1, 0, 2'd3, 0); chk("R10 ckout read", rdata[0] ? 16'h1 : 16'h0, 16'h0000);
        // Random phase against the model.
        for (int i = 0; i < 600; i++) begin
            eng = 4'($urandom);
            op(1'($urandom), 1'($urandom), 2'($urandom), 16'($urandom));
        end
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule